// File: doc/BRIEF.md
# Master Clock Failover Selector

This block builds the internal master clock from one of two sources: the clock coming out of a PLL, or a free-running external oscillator clock. A two-bit mode input selects the behaviour. Two modes pin the choice to one source. One automatic mode prefers the PLL and falls back to the oscillator when the PLL lock flag drops. It returns to the PLL once lock has been held steadily for a programmable number of oscillator cycles. The last mode prefers the oscillator.

Every change of source is a break-before-make handoff. The active clock is gated off on its own falling edge. The other clock is enabled, on its own falling edge, only after a two-flop synchronised acknowledge shows that the first one is off. As a result, no high or low phase on the output is shorter than a half period of either source. All control logic runs on the oscillator clock, which is assumed always present. A status output names the source that is driving the output. A separate PLL reference choice is registered and passed straight through to the PLL.

Top module: `mclk_failover_sel`

## Requirements
- R1: Mode 2'b00 (fixed PLL) makes the PLL clock drive `mclk_out`, with `src_is_ext` = 0, whatever the lock flag does.
- R2: Mode 2'b01 (fixed oscillator) makes the oscillator drive `mclk_out`, with `src_is_ext` = 1, and the lock flag has no effect.
- R3: In mode 2'b10 (auto, PLL preferred), a lock flag held low for 4 or more consecutive oscillator cycles moves the output to the oscillator.
- R4: In mode 2'b10, a low pulse on the lock flag that lasts fewer than 4 oscillator cycles leaves the PLL selected.
- R5: In mode 2'b10, after a fallback, the output returns to the PLL only after the lock flag has stayed high for `relock_cycles` consecutive oscillator cycles, and not before.
- R6: Mode 2'b11 (auto, oscillator preferred) keeps the oscillator on the output whatever the lock flag does.
- R7: No high or low phase of `mclk_out` is shorter than the shorter half period of the two sources, including across a change of source.
- R8: `pll_ref_sel` equals `ref_sel_in` as it stood at the previous rising oscillator edge (1 = serial-port frame clock, 0 = clock recovered from the S/PDIF stream).
- R9: `src_is_ext` changes only after the new source's gate is open and the old one's is closed. Once it has settled, `mclk_out` follows the source it names.
- R10: While `rst_n` is low, `mclk_out` is 0, `src_is_ext` is 1 and `pll_ref_sel` is 0. After release the lock is treated as lost, so mode 2'b10 starts on the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | External oscillator clock; also clocks all control logic |
| clk_pll | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| sw_mode | input | 2 | Source mode: 00 fixed PLL, 01 fixed oscillator, 10 auto PLL-preferred, 11 auto oscillator-preferred |
| relock_cycles | input | RELOCK_W | Oscillator cycles of steady lock required before returning to the PLL |
| ref_sel_in | input | 1 | Requested PLL reference (1 frame clock, 0 recovered S/PDIF clock) |
| mclk_out | output | 1 | Glitch-free master clock |
| src_is_ext | output | 1 | 1 when the oscillator drives `mclk_out`, 0 when the PLL does |
| pll_ref_sel | output | 1 | Registered PLL reference choice |

## Verification
The reference choice is due one oscillator cycle after it is driven, and it is compared on every cycle. A change of source passes through the lock synchroniser, the 4-cycle filter, a select register and two cross-domain handshakes, so the status and the output are due about fourteen oscillator cycles later. For that reason the model checks them only once its own expected source has been steady for 24 cycles. The model applies the lock filter and the relock count at exactly the thresholds set by the requirements. Because the synchroniser delay is the same at both ends of a lock run, early-return and short-glitch mistakes show up as a wrong status inside a window where the source should be steady. Runt pulses are caught by timing every output edge and keeping the minimum phase width.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    MODE_MAN_PLL  = 2'b00,
    MODE_MAN_EXT  = 2'b01,
    MODE_AUTO_PLL = 2'b10,
    MODE_AUTO_EXT = 2'b11
  } sw_mode_e;

  // Source wanted for a mode and the fallback flag: 1 = oscillator.
  function automatic logic pick_ext(sw_mode_e m, logic fallback);
    case (m)
      MODE_MAN_PLL:  return 1'b0;
      MODE_MAN_EXT:  return 1'b1;
      MODE_AUTO_PLL: return fallback;
      default:       return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/mcs_sync2.sv
module mcs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mcs_lock_monitor.sv
module mcs_lock_monitor #(
  parameter int FILT_LEN = 4,
  parameter int RELOCK_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_in,
  input  logic [RELOCK_W-1:0] relock_cycles,
  output logic                fallback
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] FILT_TOP = FW'(FILT_LEN);

  logic                lk_s;
  logic [FW-1:0]       lo_cnt;
  logic [RELOCK_W-1:0] hi_cnt;
  logic                loss_seen;
  logic                relock_done;

  mcs_sync2 #(.W(1)) u_lock_sync (
    .clk(clk), .rst_n(rst_n), .d(lock_in), .q(lk_s)
  );

  // Named events for the assertions.
  assign loss_seen   = (lo_cnt == FILT_TOP);
  assign relock_done = fallback && lk_s && (hi_cnt >= relock_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      fallback <= 1'b1;
    end else begin
      if (lk_s) begin
        lo_cnt <= '0;
        if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != FILT_TOP) lo_cnt <= lo_cnt + 1'b1;
      end
      if (loss_seen)        fallback <= 1'b1;
      else if (relock_done) fallback <= 1'b0;
    end
  end

  // A fallback is only entered after a run of low lock samples.
  assert_loss_low_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loss_seen |-> !$past(lk_s));

  // Fallback rises only when the filter saw the full run.
  assert_glitch_filtered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback) |-> ($past(lo_cnt) == FILT_TOP));

  // Return to the PLL needs lock present and the hold count met.
  assert_relock_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fallback) |-> ($past(lk_s) && ($past(hi_cnt) >= $past(relock_cycles))));
endmodule

// File: rtl/mcs_gate_mux.sv
module mcs_gate_mux (
  input  logic clk_pll,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sel_ext,
  output logic mclk,
  output logic src_is_ext
);
  logic en_pll, en_ext;
  logic ext_stage, pll_release;
  logic pll_req_s, pll_en_x;

  // PLL gate state seen in the oscillator domain.
  mcs_sync2 #(.W(1)) u_pll_to_ext (
    .clk(clk_ext), .rst_n(rst_n), .d(en_pll), .q(pll_en_x)
  );

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      ext_stage   <= 1'b0;
      pll_release <= 1'b0;
      src_is_ext  <= 1'b1;
    end else begin
      ext_stage   <= sel_ext & ~pll_en_x;
      pll_release <= ~sel_ext & ~en_ext;
      if (en_ext)        src_is_ext <= 1'b1;
      else if (pll_en_x) src_is_ext <= 1'b0;
    end
  end

  always_ff @(negedge clk_ext or negedge rst_n) begin
    if (!rst_n) en_ext <= 1'b0;
    else        en_ext <= ext_stage;
  end

  // Oscillator-side release seen in the PLL domain.
  mcs_sync2 #(.W(1)) u_ext_to_pll (
    .clk(clk_pll), .rst_n(rst_n), .d(pll_release), .q(pll_req_s)
  );

  always_ff @(negedge clk_pll or negedge rst_n) begin
    if (!rst_n) en_pll <= 1'b0;
    else        en_pll <= pll_req_s;
  end

  assign mclk = (clk_pll & en_pll) | (clk_ext & en_ext);

  // Oscillator gate opens only after the PLL gate was seen closed.
  assert_make_after_break_R7: assert property (@(posedge clk_ext) disable iff (!rst_n)
    $rose(en_ext) |-> !$past(pll_en_x));

  assert_status_ext_done_R9: assert property (@(posedge clk_ext) disable iff (!rst_n)
    $rose(src_is_ext) |-> $past(en_ext));

  assert_status_pll_done_R9: assert property (@(posedge clk_ext) disable iff (!rst_n)
    $fell(src_is_ext) |-> ($past(pll_en_x) && !$past(en_ext)));
endmodule

// File: rtl/mclk_failover_sel.sv
module mclk_failover_sel
  import mcs_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int RELOCK_W = 16
) (
  input  logic                clk_ext,
  input  logic                clk_pll,
  input  logic                rst_n,
  input  logic                pll_locked,
  input  logic [1:0]          sw_mode,
  input  logic [RELOCK_W-1:0] relock_cycles,
  input  logic                ref_sel_in,
  output logic                mclk_out,
  output logic                src_is_ext,
  output logic                pll_ref_sel
);
  sw_mode_e mode_q;
  logic     fallback;
  logic     sel_ext_q;

  mcs_lock_monitor #(.FILT_LEN(FILT_LEN), .RELOCK_W(RELOCK_W)) u_lock (
    .clk(clk_ext), .rst_n(rst_n), .lock_in(pll_locked),
    .relock_cycles(relock_cycles), .fallback(fallback)
  );

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_MAN_EXT;
      sel_ext_q   <= 1'b1;
      pll_ref_sel <= 1'b0;
    end else begin
      mode_q      <= sw_mode_e'(sw_mode);
      sel_ext_q   <= pick_ext(mode_q, fallback);
      pll_ref_sel <= ref_sel_in;
    end
  end

  mcs_gate_mux u_mux (
    .clk_pll(clk_pll), .clk_ext(clk_ext), .rst_n(rst_n),
    .sel_ext(sel_ext_q), .mclk(mclk_out), .src_is_ext(src_is_ext)
  );

  assert_fixed_pll_R1: assert property (@(posedge clk_ext) disable iff (!rst_n)
    (mode_q == MODE_MAN_PLL) |=> !sel_ext_q);

  assert_fixed_ext_R2: assert property (@(posedge clk_ext) disable iff (!rst_n)
    (mode_q == MODE_MAN_EXT) |=> sel_ext_q);

  assert_auto_ext_R6: assert property (@(posedge clk_ext) disable iff (!rst_n)
    (mode_q == MODE_AUTO_EXT) |=> sel_ext_q);

  assert_ref_follow_R8: assert property (@(posedge clk_ext) disable iff (!rst_n)
    1'b1 |=> (pll_ref_sel == $past(ref_sel_in)));
endmodule

// File: tb/tb_mclk_failover_sel.sv
`timescale 1ns/1ps
module tb_mclk_failover_sel;
  localparam int RW     = 16;
  localparam int NHOLD  = 30;
  localparam int SETTLE = 24;
  localparam int FILT   = 4;

  logic          clk_ext = 1'b0;
  logic          clk_pll = 1'b0;
  logic          rst_n = 1'b1;
  logic          pll_locked = 1'b0;
  logic          ref_sel_in = 1'b0;
  logic [1:0]    sw_mode = 2'b10;
  logic [RW-1:0] relock_cycles = RW'(NHOLD);
  logic          mclk_out, src_is_ext, pll_ref_sel;

  always #2 clk_ext = ~clk_ext;
  initial begin
    #0.5;
    forever #3 clk_pll = ~clk_pll;
  end

  mclk_failover_sel #(.FILT_LEN(FILT), .RELOCK_W(RW)) dut (
    .clk_ext(clk_ext), .clk_pll(clk_pll), .rst_n(rst_n),
    .pll_locked(pll_locked), .sw_mode(sw_mode), .relock_cycles(relock_cycles),
    .ref_sel_in(ref_sel_in), .mclk_out(mclk_out), .src_is_ext(src_is_ext),
    .pll_ref_sel(pll_ref_sel)
  );

  int      total = 0, bad = 0, cyc = 0;
  int      low_run = 0, high_run = 0, last_change = 0;
  bit      fb_m = 1'b1, sel_prev = 1'b1, in_reset = 1'b1, done = 1'b0;
  bit      have_edge = 1'b0;
  realtime last_edge = 0.0, min_w = 1000.0;
  string   phase = "R10";

  // Oscillator wanted: any mode except 00, and in 10 only while fallen back.
  function automatic bit want_osc(logic [1:0] m, bit f);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b10) return f;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: act=%0d exp=%0d", req, what, cyc, act, exp);
    end
  endtask

  always @(mclk_out) begin
    if (rst_n && !in_reset && !done) begin
      if (have_edge && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
      last_edge = $realtime;
      have_edge = 1'b1;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_ext);
      #1;
      cyc++;
      if (in_reset) begin
        chk(mclk_out == 1'b0, "R10", "mclk in reset", int'(mclk_out), 0);
        chk(src_is_ext == 1'b1, "R10", "status in reset", int'(src_is_ext), 1);
        chk(pll_ref_sel == 1'b0, "R10", "ref in reset", int'(pll_ref_sel), 0);
      end else begin
        if (pll_locked) begin high_run++; low_run = 0; end
        else begin low_run++; high_run = 0; end
        if (low_run >= FILT) fb_m = 1'b1;
        else if (fb_m && high_run >= NHOLD) fb_m = 1'b0;
        if (want_osc(sw_mode, fb_m) != sel_prev) begin
          sel_prev = want_osc(sw_mode, fb_m);
          last_change = cyc;
        end
        chk(pll_ref_sel == ref_sel_in, "R8", "pll_ref_sel", int'(pll_ref_sel), int'(ref_sel_in));
        if (cyc - last_change >= SETTLE) begin
          chk(src_is_ext == sel_prev, phase, "src_is_ext", int'(src_is_ext), int'(sel_prev));
          chk(mclk_out == (sel_prev ? clk_ext : clk_pll), "R9", "mclk vs source",
              int'(mclk_out), int'(sel_prev ? clk_ext : clk_pll));
        end
      end
    end
  endtask

  initial begin
    #0.2 rst_n = 1'b0;
    tick(8);
    // Release at a sample point; lock assumed lost.
    rst_n = 1'b0;
    in_reset = 1'b0;
    rst_n = 1'b1;
    last_change = cyc;
    phase = "R10";   tick(40);
    phase = "R5";    pll_locked = 1'b1; tick(NHOLD + SETTLE + 20);
    ref_sel_in = 1'b1;
    phase = "R4";    pll_locked = 1'b0; tick(2); pll_locked = 1'b1; tick(50);
    pll_locked = 1'b0; tick(3); pll_locked = 1'b1; tick(40);
    phase = "R3";    pll_locked = 1'b0; tick(60);
    phase = "R5";    pll_locked = 1'b1; tick(NHOLD + SETTLE + 20);
    ref_sel_in = 1'b0;
    phase = "R1";    sw_mode = 2'b00; pll_locked = 1'b0; tick(60);
    phase = "R2";    sw_mode = 2'b01; tick(30); pll_locked = 1'b1; tick(30);
    ref_sel_in = 1'b1; pll_locked = 1'b0; tick(30);
    phase = "R6";    sw_mode = 2'b11; pll_locked = 1'b1; tick(30);
    pll_locked = 1'b0; tick(30);
    phase = "R1";    sw_mode = 2'b00; pll_locked = 1'b1; tick(60);
    done = 1'b1;
    chk(have_edge, "R7", "output toggles", int'(have_edge), 1);
    chk(min_w >= 1.999, "R7", "min phase width ps", int'(min_w * 1000.0), 2000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R9 watchdog expired: act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule